// File: doc/BRIEF.md
# Complementary PWM Triangle Carrier with Buffered Limits

This block produces the triangular carrier used by a three-phase complementary PWM timer. It has two up/down counters that step in the same direction on every clock. The lagging counter runs between zero and its own upper limit. The leading counter runs a fixed offset above it, and that offset is the dead time (or one, when dead time is switched off). So the leading counter peaks at its own limit in the same clock in which the lagging counter peaks at its limit. The block flags the crest of the carrier (the turn at the top) and the trough (the turn at the bottom).

Software never writes the active limits directly. It writes shadow registers through a single-cycle write port, and that port always accepts a write in its cycle, with no back-pressure. At the carrier point chosen by a two-bit transfer mode, both shadow limits are copied into the active limits in the same clock, and an update strobe pulses. A transfer at the trough shapes the rising half that follows at once, so the current carrier cycle already uses it. A transfer at the crest leaves the falling half unchanged, so it takes effect from the next cycle. The dead-time shadow is adopted only while the carrier is stopped.

Top module: `cpwm_carrier`

## Requirements
- R1: On reset both counters read 0 and all flags are low. While `run` is low, the lagging counter is loaded with 0 and the leading counter with the dead-time shadow value (or 1 when `dead_en` is low), and all flags stay low.
- R2: While running, both counters step up or down together, and the leading counter stays exactly the active offset above the lagging one. The offset is the active dead time when `dead_en` is 1 and 1 otherwise.
- R3: The active limits satisfy lead limit = lag limit + offset whenever the carrier runs. Software must write shadow values that keep this relation, and an assertion flags any active pair that breaks it.
- R4: The lagging counter counts up from 0 to its active limit and then down to 0, so one carrier cycle is twice the lag limit in clocks. The first clock of running steps it from 0 to 1.
- R5: `crest` is high for exactly one clock, when the counters rise into the lead limit (lagging counter at its limit). `trough` is high for one clock, when the lagging counter reaches 0 while falling.
- R6: Both active limits are copied from their shadows in the same clock, and only when a shadow write is pending. Bit 0 of `xfer_mode` enables transfer at the crest, bit 1 enables it at the trough, both bits set enables both points, and 00 disables transfers.
- R7: `upd` is high in exactly the clock in which a transfer happens, and it coincides with an enabled `crest` or `trough`.
- R8: A crest transfer leaves the current falling half unchanged, so the next peak uses the new limit. A trough transfer makes the very next peak use the new limit.
- R9: A shadow write in the same clock as a transfer is not taken by that transfer. It stays pending and is transferred, with another `upd` pulse, at the next selected point.
- R10: `wr_sel` encodes 0 = lead-limit shadow, 1 = lag-limit shadow, 2 = dead-time shadow. A write with `wr_sel` = 3 changes nothing and does not make a transfer pending.
- R11: A dead-time write while running does not change the counter offset. `dead_en` and the active dead time change only while `run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Carrier runs while high, held at load values while low |
| dead_en | input | 1 | 1: offset is the dead time, 0: offset is 1 |
| xfer_mode | input | 2 | Bit 0 crest transfer, bit 1 trough transfer |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 2 | Shadow select (see R10) |
| wr_data | input | CW | Shadow write value |
| cnt_lead | output | CW | Leading counter |
| cnt_lag | output | CW | Lagging counter |
| crest | output | 1 | Carrier top turn pulse |
| trough | output | 1 | Carrier bottom turn pulse |
| upd | output | 1 | Shadow-to-active transfer pulse |

## Verification
Both counters are registers, so a change in `run` or in the count direction shows at the counter outputs one edge later. `crest`, `trough` and `upd` are decoded from the registered state in the same clock as the count value they mark. An active limit copied at an edge first steers the turn that is decided on that new value, which is the next peak for a crest transfer and the rising half just begun for a trough transfer. The bench keeps a cycle model that it advances at each rising edge with the inputs that were applied. It compares all five outputs with that model at the following falling edge. Directed checks are made in the exact clock of a crest or trough, so each one covers the cycle in which the result is due.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    SEL_LEAD_LIM = 2'd0,
    SEL_LAG_LIM  = 2'd1,
    SEL_DEAD     = 2'd2,
    SEL_UNUSED   = 2'd3
  } wsel_e;
  localparam int MODE_CREST_BIT  = 0;
  localparam int MODE_TROUGH_BIT = 1;
endpackage

// File: rtl/cpwm_updown.sv
module cpwm_updown #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] load_val,
  input  logic          step_up,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= load_val;
    else if (step_up) cnt <= cnt + 1'b1;
    else              cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/cpwm_dir.sv
module cpwm_dir #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cnt_lag,
  input  logic [CW-1:0] lag_lim,
  output logic          step_up,
  output logic          dir_up
);
  logic at_top, at_bot;
  assign at_top  = (cnt_lag == lag_lim);
  assign at_bot  = (cnt_lag == '0);
  assign step_up = dir_up ? !at_top : at_bot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dir_up <= 1'b1;
    else if (!run) dir_up <= 1'b1;
    else           dir_up <= step_up;
  end

  AST_TURN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dir_up && at_bot) |=> (!run || cnt_lag == CW'(1))); // R4
endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow
  import cpwm_pkg::*;
#(
  parameter int CW       = 16,
  parameter int RST_LAG  = 1,
  parameter int RST_DEAD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          dead_en,
  input  logic [1:0]    xfer_mode,
  input  logic          at_crest,
  input  logic          at_trough,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] lead_lim,
  output logic [CW-1:0] lag_lim,
  output logic [CW-1:0] dead_act,
  output logic [CW-1:0] dead_shd,
  output logic          xfer
);
  localparam logic [CW-1:0] RST_LAG_V  = CW'(RST_LAG);
  localparam logic [CW-1:0] RST_DEAD_V = CW'(RST_DEAD);
  localparam logic [CW-1:0] RST_LEAD_V = CW'(RST_LAG + RST_DEAD);

  logic [CW-1:0] lead_shd, lag_shd;
  logic          pend, wr_hit;
  wsel_e         sel;

  assign sel    = wsel_e'(wr_sel);
  assign wr_hit = wr_en && (sel != SEL_UNUSED);
  assign xfer   = run && pend &&
                  ((xfer_mode[MODE_CREST_BIT] && at_crest) ||
                   (xfer_mode[MODE_TROUGH_BIT] && at_trough));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_shd <= RST_LEAD_V;
      lag_shd  <= RST_LAG_V;
      dead_shd <= RST_DEAD_V;
    end else if (wr_en) begin
      case (sel)
        SEL_LEAD_LIM: lead_shd <= wr_data;
        SEL_LAG_LIM:  lag_shd  <= wr_data;
        SEL_DEAD:     dead_shd <= wr_data;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_lim <= RST_LEAD_V;
      lag_lim  <= RST_LAG_V;
      dead_act <= RST_DEAD_V;
      pend     <= 1'b0;
    end else if (!run) begin
      lead_lim <= lead_shd;
      lag_lim  <= lag_shd;
      dead_act <= dead_shd;
      pend     <= wr_hit;
    end else begin
      if (xfer) begin
        lead_lim <= lead_shd;
        lag_lim  <= lag_shd;
      end
      pend <= (pend && !xfer) || wr_hit;
    end
  end

  AST_PAIR_REL: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (lead_lim == lag_lim + (dead_en ? dead_act : CW'(1)))); // R3
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(xfer)) |-> ($stable(lead_lim) && $stable(lag_lim) && $stable(dead_act))); // R6
endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier #(
  parameter int CW       = 16,
  parameter int RST_LAG  = 1,
  parameter int RST_DEAD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          dead_en,
  input  logic [1:0]    xfer_mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt_lead,
  output logic [CW-1:0] cnt_lag,
  output logic          crest,
  output logic          trough,
  output logic          upd
);
  localparam int NCNT = 2;

  logic [CW-1:0] lead_lim, lag_lim, dead_act, dead_shd;
  logic [CW-1:0] off_act, off_shd;
  logic [CW-1:0] load_v [NCNT];
  logic [CW-1:0] cnt_v  [NCNT];
  logic          step_up, dir_up;

  assign off_shd = dead_en ? dead_shd : CW'(1);
  assign off_act = dead_en ? dead_act : CW'(1);

  assign load_v[0] = off_shd;
  assign load_v[1] = '0;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    cpwm_updown #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run),
      .load_val(load_v[g]), .step_up(step_up), .cnt(cnt_v[g])
    );
  end

  assign cnt_lead = cnt_v[0];
  assign cnt_lag  = cnt_v[1];

  cpwm_dir #(.CW(CW)) u_dir (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cnt_lag(cnt_lag), .lag_lim(lag_lim),
    .step_up(step_up), .dir_up(dir_up)
  );

  assign crest  = run && dir_up && (cnt_lead == lead_lim);
  assign trough = run && !dir_up && (cnt_lag == '0);

  cpwm_shadow #(.CW(CW), .RST_LAG(RST_LAG), .RST_DEAD(RST_DEAD)) u_shadow (
    .clk(clk), .rst_n(rst_n), .run(run), .dead_en(dead_en),
    .xfer_mode(xfer_mode), .at_crest(crest), .at_trough(trough),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lead_lim(lead_lim), .lag_lim(lag_lim),
    .dead_act(dead_act), .dead_shd(dead_shd), .xfer(upd)
  );

  AST_CNT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_lead - cnt_lag == off_act)); // R2
  AST_CREST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    crest |=> !crest); // R5
  AST_UPD_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ((crest && xfer_mode[0]) || (trough && xfer_mode[1]))); // R7
endmodule

// File: tb/cpwm_carrier_tb_top.sv
module cpwm_carrier_tb_top;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0, dten_i = 1'b1, wr_en_i = 1'b0;
  logic [1:0] mode_i = 2'd0, wr_sel_i = 2'd0;
  logic [CW-1:0] wr_data_i = '0;
  logic [CW-1:0] cnt_lead, cnt_lag;
  logic crest, trough, upd;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  int  m_sh1 = 2, m_sh2 = 1, m_shd = 1, m_a1 = 2, m_a2 = 1, m_adt = 1;
  int  m_c1 = 0, m_c2 = 0;
  bit  m_up = 1'b1, m_pend = 1'b0;
  int  cur_dt = 1;

  always #4 clk = ~clk;

  cpwm_carrier #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run_i), .dead_en(dten_i),
    .xfer_mode(mode_i), .wr_en(wr_en_i), .wr_sel(wr_sel_i), .wr_data(wr_data_i),
    .cnt_lead(cnt_lead), .cnt_lag(cnt_lag), .crest(crest), .trough(trough), .upd(upd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit e_cr, e_tr, xf, st;
    #1;
    e_cr = run_i && m_up && (m_c1 == m_a1);
    e_tr = run_i && !m_up && (m_c2 == 0);
    xf   = run_i && m_pend && ((mode_i[0] && e_cr) || (mode_i[1] && e_tr));
    chk("R4 lagging count", int'(cnt_lag), m_c2);
    chk("R2 leading count", int'(cnt_lead), m_c1);
    chk("R5 crest flag", int'(crest), int'(e_cr));
    chk("R5 trough flag", int'(trough), int'(e_tr));
    chk("R7 update strobe", int'(upd), int'(xf));
    @(posedge clk);
    if (!run_i) begin
      m_a1 = m_sh1; m_a2 = m_sh2; m_adt = m_shd;
      m_c1 = dten_i ? m_shd : 1; m_c2 = 0; m_up = 1'b1;
      m_pend = wr_en_i && (wr_sel_i != 2'd3);
    end else begin
      st = m_up ? (m_c2 != m_a2) : (m_c2 == 0);
      m_c1 = st ? m_c1 + 1 : m_c1 - 1;
      m_c2 = st ? m_c2 + 1 : m_c2 - 1;
      m_up = st;
      if (xf) begin m_a1 = m_sh1; m_a2 = m_sh2; end
      m_pend = (m_pend && !xf) || (wr_en_i && (wr_sel_i != 2'd3));
    end
    if (wr_en_i) begin
      case (wr_sel_i)
        2'd0: m_sh1 = int'(wr_data_i);
        2'd1: m_sh2 = int'(wr_data_i);
        2'd2: m_shd = int'(wr_data_i);
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input int data);
    wr_en_i = 1'b1; wr_sel_i = sel[1:0]; wr_data_i = data[CW-1:0];
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic start(input bit en, input int dt, input int l2);
    run_i = 1'b0;
    step();
    dten_i = en; cur_dt = dt;
    wr(2, dt);
    wr(0, l2 + (en ? dt : 1));
    wr(1, l2);
    step(); step();
    run_i = 1'b1;
  endtask

  task automatic wait_crest();
    while (!crest) step();
  endtask

  task automatic wait_trough();
    while (!trough) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4 actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #2;
    chk("R1 reset lead", int'(cnt_lead), 0);
    chk("R1 reset lag", int'(cnt_lag), 0);
    chk("R1 reset flags", int'({crest, trough, upd}), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();

    // R8 crest transfer: current falling half unchanged, next peak new
    start(1'b1, 3, 10);
    mode_i = 2'b01;
    wait_crest(); step();
    wr(0, 9); wr(1, 6);
    wait_crest();
    chk("R8 crest transfer keeps peak", int'(cnt_lag), 10);
    chk("R6 strobe at crest", int'(upd), 1);
    step();
    wait_crest();
    chk("R8 new peak from next cycle", int'(cnt_lag), 6);
    step();

    // R9 write in the transfer clock stays pending
    wr(0, 9); wr(1, 6);
    wait_crest();
    wr_en_i = 1'b1; wr_sel_i = 2'd1; wr_data_i = 16'd6;
    step();
    wr_en_i = 1'b0;
    wait_crest();
    chk("R9 held write transfers at next point", int'(upd), 1);
    step();
    wait_crest();
    chk("R9 pending cleared after transfer", int'(upd), 0);
    step();

    // R10 unused select
    wr(3, 16'h55);
    wait_crest();
    chk("R10 unused select makes no transfer", int'(upd), 0);
    step();

    // R11 dead time write while running
    wr(2, 7);
    repeat (30) step();
    chk("R11 offset fixed while running", int'(cnt_lead) - int'(cnt_lag), 3);

    // R6 mode none
    mode_i = 2'b00;
    wr(0, 13); wr(1, 10);
    wait_crest(); step();
    wait_crest();
    chk("R6 no transfer with mode 00", int'(cnt_lag), 6);
    chk("R6 no strobe with mode 00", int'(upd), 0);
    step();

    // R8 trough transfer: current cycle
    mode_i = 2'b10;
    wait_trough();
    chk("R6 strobe at trough", int'(upd), 1);
    step();
    wait_crest();
    chk("R8 trough transfer sets current peak", int'(cnt_lag), 10);
    chk("R3 lead limit equals lag limit plus dead time", int'(cnt_lead), 13);

    // R1 idle loads
    run_i = 1'b0;
    step(); step();
    chk("R1 idle lead load is dead time", int'(cnt_lead), 7);
    chk("R1 idle lag load", int'(cnt_lag), 0);
    dten_i = 1'b0;
    step();
    chk("R1 idle lead load without dead time", int'(cnt_lead), 1);

    // random phases per transfer mode
    for (int md = 1; md < 4; md++) begin
      start(1'($urandom % 2), 1 + int'($urandom % 8), 4 + int'($urandom % 30));
      mode_i = md[1:0];
      for (int k = 0; k < 3000; k++) begin
        if ((crest || trough) && ($urandom % 2 == 0)) begin
          int l2;
          l2 = 4 + int'($urandom % 37);
          step();
          wr(0, l2 + (dten_i ? cur_dt : 1));
          wr(1, l2);
        end else if ($urandom % 16 == 0) begin
          wr(3, int'($urandom % 65536));
        end else begin
          step();
        end
      end
      chk("R2 offset at phase end", int'(cnt_lead) - int'(cnt_lag), dten_i ? cur_dt : 1);
    end
    run_i = 1'b0;
    step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule